// File: doc/BRIEF.md
# Operand Register File with Gated Read Selects

This block is a byte-wide register file of eight entries with two read ports and one write port. Both read addresses and the write address come straight from a 16-bit instruction word. Port A reads the register named by instruction bits 2:0, which is also the write target. Port B reads the register named by bits 5:3. Each read port is a three-level binary multiplexer tree.

The select lines of each tree are held in registers that load only when the current instruction uses that operand. Lines that steer only one half of a tree also load only when that half is addressed. An instruction that takes an immediate, or one that has no use for the first operand, therefore leaves the tree select lines unchanged and causes no toggling inside the multiplexers. To spread fan-out, the lower and upper halves use address bits 0 and 1 in opposite roles, and registers 5 and 6 sit in each other's leaf positions. The port still returns the register named by the logical address.

A select register loads on a rising clock edge. After that edge, the port output shows the current contents of the register it selects. The output has no combinational path from the instruction input.

Top module: `gated_regfile`

## Requirements
- R1: When `wr_en` is high, `wr_data` is written on the rising clock edge into the register at address `instr[2:0]`. Before that edge, a port that selects this register still shows the old value. After the edge it shows the new one.
- R2: On a clock edge where a port is enabled, port A loads address `instr[2:0]` and port B loads address `instr[5:3]`. After that edge, each port outputs the contents of the register it has loaded.
- R3: Port A is disabled exactly when `instr[15]`=1 and `instr[13]`=0, whatever the value of `instr[14]`.
- R4: Port B is disabled whenever `instr[10]`=1. It is also disabled when `instr[11]`=1 and bit 11 acts as the immediate flag.
- R5: Bit 11 acts as the immediate flag only when `instr[15]`=0, or when both `instr[14]` and `instr[13]` are 0. For any other prefix, bit 11 has no effect on port B.
- R6: A disabled port keeps its previous address. Its output goes on showing that same register, including any value written into it.
- R7: All eight logical addresses read the register they name on both ports, including addresses 5 and 6.
- R8: The select lines of the lower half of a tree (address bit 2 = 0) load only when an enabled access addresses that half. The select lines of the upper half likewise load only when an enabled access addresses the upper half.
- R9: A synchronous high `rst` clears all eight registers and all held selects to 0, so both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word supplying addresses and gating bits |
| wr_en | input | 1 | Write strobe for the register at instr[2:0] |
| wr_data | input | 8 | Byte to be written |
| rd_a_data | output | 8 | Port A read data (address from instr[2:0]) |
| rd_b_data | output | 8 | Port B read data (address from instr[5:3]) |

## Verification
A directed pass first fills all eight registers with distinct bytes and then reads every address on both ports. This separates a correct tree from one that drops the exchange of registers 5 and 6 or the swap of bits 0 and 1 between the halves. The next directed group drives each opcode prefix with bits 10 and 11 set and cleared. A port that reloads when it should hold then shows the wrong register, which exposes any error in the prefix terms of the enables. Writes to a register a disabled port still points at confirm that the port tracks that register rather than a latched value. A long seeded random run, biased toward the gating prefixes, then mixes writes, holds and reloads. In that run it catches same-edge write ordering and half-tree reload errors.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 3;
  localparam int NREG    = 1 << ADDR_W;

  typedef struct packed {
    logic top;      // address bit 2
    logic lo_leaf;  // lower half leaf level: bit 0
    logic lo_mid;   // lower half middle level: bit 1
    logic hi_leaf;  // upper half leaf level: bit 1 (swapped)
    logic hi_mid;   // upper half middle level: bit 0 (swapped)
  } tree_sel_t;

  // Does bit 11 act as the immediate-8 flag for this opcode prefix?
  function automatic logic imm8_flag_live(input logic [INSTR_W-1:0] ins);
    return !ins[15] || (!ins[14] && !ins[13]);
  endfunction

  function automatic logic port_a_used(input logic [INSTR_W-1:0] ins);
    return !(ins[15] && !ins[13]);
  endfunction

  function automatic logic port_b_used(input logic [INSTR_W-1:0] ins);
    return !ins[10] && !(ins[11] && imm8_flag_live(ins));
  endfunction

  function automatic tree_sel_t sel_from_addr(input logic [ADDR_W-1:0] a);
    tree_sel_t s;
    s.top     = a[2];
    s.lo_leaf = a[0];
    s.lo_mid  = a[1];
    s.hi_leaf = a[1];
    s.hi_mid  = a[0];
    return s;
  endfunction

  // Physical leaf position -> logical register (5 and 6 exchanged).
  function automatic int unsigned phys_to_reg(input int unsigned p);
    if (p == 5) return 6;
    if (p == 6) return 5;
    return p;
  endfunction
endpackage

// File: rtl/rfg_decode.sv
module rfg_decode
  import rfg_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               en_a,
  output logic               en_b,
  output logic [ADDR_W-1:0]  addr_a,
  output logic [ADDR_W-1:0]  addr_b
);
  always_comb begin
    en_a   = port_a_used(instr);
    en_b   = port_b_used(instr);
    addr_a = instr[2:0];
    addr_b = instr[5:3];
  end
endmodule

// File: rtl/rfg_sel_hold.sv
module rfg_sel_hold
  import rfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output tree_sel_t         sel_q
);
  tree_sel_t nx;
  logic      load_lo, load_hi;

  always_comb begin
    nx      = sel_from_addr(addr);
    load_lo = en && !addr[2];
    load_hi = en &&  addr[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else begin
      if (en) sel_q.top <= nx.top;
      if (load_lo) begin
        sel_q.lo_leaf <= nx.lo_leaf;
        sel_q.lo_mid  <= nx.lo_mid;
      end
      if (load_hi) begin
        sel_q.hi_leaf <= nx.hi_leaf;
        sel_q.hi_mid  <= nx.hi_mid;
      end
    end
  end

  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sel_q));
  p_upper_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !addr[2]) |=> ($stable(sel_q.hi_leaf) && $stable(sel_q.hi_mid)));
  p_lower_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (en && addr[2]) |=> ($stable(sel_q.lo_leaf) && $stable(sel_q.lo_mid)));
endmodule

// File: rtl/rfg_store.sv
module rfg_store
  import rfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          waddr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NREG-1:0][DATA_W-1:0] regs
);
  always_ff @(posedge clk) begin
    if (rst)     regs <= '0;
    else if (we) regs[waddr] <= wdata;
  end
endmodule

// File: rtl/rfg_mux_tree.sv
module rfg_mux_tree
  import rfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  input  tree_sel_t                   sel,
  output logic [DATA_W-1:0]           dout
);
  localparam int NLEAF = NREG / 2;

  logic [NLEAF-1:0][DATA_W-1:0] leaf;
  logic [DATA_W-1:0]            lo_half, hi_half;

  for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
    localparam int unsigned R0 = phys_to_reg(2 * k);
    localparam int unsigned R1 = phys_to_reg(2 * k + 1);
    logic leaf_sel;
    assign leaf_sel = (k < NLEAF / 2) ? sel.lo_leaf : sel.hi_leaf;
    assign leaf[k]  = leaf_sel ? regs[R1] : regs[R0];
  end

  always_comb begin
    lo_half = sel.lo_mid ? leaf[1] : leaf[0];
    hi_half = sel.hi_mid ? leaf[3] : leaf[2];
    dout    = sel.top ? hi_half : lo_half;
  end
endmodule

// File: rtl/gated_regfile.sv
module gated_regfile
  import rfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        instr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_a_data,
  output logic [DATA_W-1:0]  rd_b_data
);
  logic                        en_a, en_b;
  logic [ADDR_W-1:0]           addr_a, addr_b;
  tree_sel_t                   sel_a, sel_b;
  logic [NREG-1:0][DATA_W-1:0] regs;

  rfg_decode u_dec (
    .instr(instr), .en_a(en_a), .en_b(en_b), .addr_a(addr_a), .addr_b(addr_b)
  );

  rfg_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(addr_a), .wdata(wr_data), .regs(regs)
  );

  rfg_sel_hold u_hold_a (.clk(clk), .rst(rst), .en(en_a), .addr(addr_a), .sel_q(sel_a));
  rfg_sel_hold u_hold_b (.clk(clk), .rst(rst), .en(en_b), .addr(addr_b), .sel_q(sel_b));

  rfg_mux_tree #(.DATA_W(DATA_W)) u_tree_a (.regs(regs), .sel(sel_a), .dout(rd_a_data));
  rfg_mux_tree #(.DATA_W(DATA_W)) u_tree_b (.regs(regs), .sel(sel_b), .dout(rd_b_data));

  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (regs[$past(addr_a)] == $past(wr_data)));
  p_read_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (en_a && !wr_en) |=> (rd_a_data == regs[$past(addr_a)]));
  p_prefix_blocks_a_r3: assert property (@(posedge clk) disable iff (rst)
    (instr[15] && !instr[13]) |-> !en_a);
  p_imm4_blocks_b_r4: assert property (@(posedge clk) disable iff (rst)
    instr[10] |-> !en_b);
  p_hold_a_r6: assert property (@(posedge clk) disable iff (rst)
    (!en_a && !wr_en) |=> $stable(rd_a_data));
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0));
endmodule

// File: tb/tb_gated_regfile.sv
module tb_gated_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_a_data, rd_b_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] mem [8];
  logic [2:0] qa, qb;

  always #2.5 clk = ~clk;

  gated_regfile dut (
    .clk(clk), .rst(rst), .instr(instr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  function automatic bit exp_en_a(input logic [15:0] ins);
    return !(ins[15:13] inside {3'b100, 3'b110});
  endfunction

  function automatic bit exp_en_b(input logic [15:0] ins);
    bit flag_is_imm;
    flag_is_imm = (ins[15] == 1'b0) || (ins[14:13] == 2'b00);
    if (ins[10]) return 0;
    if (flag_is_imm && ins[11]) return 0;
    return 1;
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // Called at a negedge: drive, check pre-edge view, clock, update model, check.
  task automatic step(input logic [15:0] ins, input bit we, input logic [7:0] wd,
                      input string tag);
    instr = ins; wr_en = we; wr_data = wd;
    #1;
    if (we && ins[2:0] == qa) check(rd_a_data, mem[qa], "R1 old value before edge");
    @(posedge clk);
    if (exp_en_a(ins)) qa = ins[2:0];
    if (exp_en_b(ins)) qb = ins[5:3];
    if (we) mem[ins[2:0]] = wd;
    @(negedge clk);
    check(rd_a_data, mem[qa], {tag, " port A"});
    check(rd_b_data, mem[qb], {tag, " port B"});
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [15:0] ins;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; instr = '0; wr_en = 1'b0; wr_data = '0;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    qa = '0; qb = '0;
    // dirty state before reset takes hold
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(16'h0000, 1'b1, 8'h5A, "R1 pre-reset write");
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mem[i] = '0;
    qa = '0; qb = '0;
    @(negedge clk);
    check(rd_a_data, 8'h00, "R9 reset port A");
    check(rd_b_data, 8'h00, "R9 reset port B");
    rst = 1'b0;

    // R1 R7: fill every register, then read each address on both ports
    for (int i = 0; i < 8; i++)
      step({13'h0000, 3'(i)}, 1'b1, 8'h10 * 8'(i) + 8'h3, "R1 fill");
    for (int i = 0; i < 8; i++)
      step({10'h000, 3'(7 - i), 3'(i)}, 1'b0, 8'h00, "R7 all addresses");

    // R3: prefix 1x0 holds port A; 101 and 111 reload
    step(16'h0005, 1'b0, 8'h00, "R2 set A=5");
    step(16'h8002, 1'b0, 8'h00, "R3 prefix 100 holds A");
    step(16'hC006, 1'b0, 8'h00, "R3 prefix 110 holds A");
    step(16'hA001, 1'b0, 8'h00, "R3 prefix 101 loads A");
    step(16'hE004, 1'b0, 8'h00, "R3 prefix 111 loads A");

    // R4 R5: bit 10 / bit 11 gating of port B
    step(16'h0030, 1'b0, 8'h00, "R2 set B=6");
    step(16'h0408, 1'b0, 8'h00, "R4 bit10 holds B");
    step(16'h0810, 1'b0, 8'h00, "R4 bit11 live holds B");
    step(16'h8818, 1'b0, 8'h00, "R4 prefix 100 bit11 holds B");
    step(16'hC828, 1'b0, 8'h00, "R5 prefix 110 ignores bit11");
    step(16'hA820, 1'b0, 8'h00, "R5 prefix 101 ignores bit11");
    step(16'hEC38, 1'b0, 8'h00, "R4 bit10 beats R5 prefix");

    // R6: disabled ports still track writes into their register
    step(16'h0035, 1'b0, 8'h00, "R2 set A=5 B=6");
    step(16'h0C06, 1'b1, 8'hC6, "R6 B held, write 6");
    step(16'h8005, 1'b1, 8'hE5, "R6 A held, write 5");

    // random mix biased toward gating prefixes
    for (int n = 0; n < 3000; n++) begin
      ins = 16'($urandom());
      if (($urandom() % 4) == 0) ins[15:13] = 3'b100;
      step(ins, 1'($urandom() % 3 == 0), 8'($urandom()), "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule